// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Page-Fault Detection

This block sits in the memory-management path of a processor. It translates a 32-bit virtual address into a physical address. The low 12 bits of the address are the offset inside a 4 KB page and pass through unchanged. The upper 20 bits form the virtual page number. That page number is compared against every stored slot in the same cycle. The result comes back one clock later, together with a response strobe.

Each slot holds the following fields:
- a page number and a frame number;
- an occupancy flag;
- a resident flag, which says whether the page is in main memory;
- dirty and referenced status bits, which the block keeps up to date itself.

When no occupied slot matches, the block reports a miss so that an external table walker can fetch the entry. It then installs that entry through the refill port. When the matching slot is not resident, the block reports a page fault and gives no address. Refills pick a slot with a round-robin pointer unless the page number is already stored; in that case the existing slot is rewritten. A flush input empties the whole buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: A request with `req_valid`=1 is answered exactly one clock later with `rsp_valid`=1. If an occupied, resident slot holds page number `req_vaddr[31:12]`, `rsp_hit`=1 and `rsp_paddr` = {stored frame number, `req_vaddr[11:0]`}.
- R2: When no occupied slot holds the requested page number, the response has `rsp_miss`=1 and `rsp_paddr`=0.
- R3: When the matching slot has its resident flag at 0, the response has `rsp_fault`=1 and `rsp_paddr`=0, and that slot's dirty and referenced bits are left unchanged.
- R4: A response carries exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault`. In a cycle without a response, all three, `rsp_paddr`, `rsp_dirty` and `rsp_ref` are 0.
- R5: Every hit sets the slot's referenced bit. On a hit, `rsp_ref` shows the value that bit had before this access.
- R6: A hit with `req_write`=1 sets the slot's dirty bit; a read hit leaves it alone. On a hit, `rsp_dirty` shows the dirty bit before this access. A refill clears both the dirty and the referenced bit of the slot it writes.
- R7: A refill of a page number not present writes the slot under the round-robin pointer, then advances the pointer by one, wrapping from ENTRIES-1 to 0. With 8 slots, the ninth new page replaces the first.
- R8: A refill of a page number already present rewrites that slot in place and leaves the pointer where it was, so no page number is ever stored twice.
- R9: `flush`=1 clears every occupancy flag and returns the pointer to slot 0 at the next edge. A refill in the same cycle as a flush is dropped.
- R10: After reset the buffer is empty, the pointer is at slot 0, and all response outputs are 0.
- R11: A lookup sees the buffer as it was before any refill or flush applied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_vaddr | input | 32 | Virtual address to translate |
| flush | input | 1 | Empty the whole buffer |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | 20 | Page number of the entry being installed |
| fill_pfn | input | 20 | Frame number of the entry being installed |
| fill_resident | input | 1 | Resident flag of the entry being installed |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No slot matched |
| rsp_fault | output | 1 | Matching slot is not resident |
| rsp_paddr | output | 32 | Physical address; 0 unless hit |
| rsp_dirty | output | 1 | Dirty bit of the slot before this hit |
| rsp_ref | output | 1 | Referenced bit of the slot before this hit |

## Verification
The lookup-compare assertion relies on the table never holding a page number twice. That holds only because refills are checked against existing tags, so the stimulus mixes new and repeated page numbers freely and has no need to avoid duplicates. The response assertions treat `req_valid` as a one-cycle strobe whose address is stable for the edge where it is sampled. The bench drives all inputs on the falling edge and deasserts them after one cycle. Same-cycle collisions between a lookup and a refill or flush are produced on purpose, in directed steps after the vector table, so that the ordering rule is exercised rather than assumed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_HIT   = 2'd1,
        RK_MISS  = 2'd2,
        RK_FAULT = 2'd3
    } rsp_kind_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int unsigned N     = 8,
    parameter int unsigned VPN_W = 20,
    localparam int unsigned IDX_W = tlb_pkg::idx_width(N)
) (
    input  logic [N-1:0]            occ,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic [N-1:0]            match,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = occ[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any = |match;

endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
    parameter int unsigned N = 8,
    localparam int unsigned IDX_W = tlb_pkg::idx_width(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clear) begin
            ptr_d = '0;
        end else if (advance) begin
            ptr_d = (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R7: pointer wraps to slot 0 after the last slot
    a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && ptr_q == IDX_W'(N - 1)) |=> (ptr_q == '0));

    // R7: pointer never leaves the slot range
    a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= IDX_W'(N - 1));

    // R9: flush returns the pointer to slot 0
    a_r9_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr_q == '0));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned PFN_W     = 20,
    parameter int unsigned ENTRIES   = 8,
    localparam int unsigned VPN_W = VA_W - PAGE_BITS,
    localparam int unsigned PA_W  = PFN_W + PAGE_BITS,
    localparam int unsigned IDX_W = tlb_pkg::idx_width(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             flush,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_resident,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_dirty,
    output logic             rsp_ref
);
    import tlb_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0]            occ;
        logic [ENTRIES-1:0]            res;
        logic [ENTRIES-1:0]            dirty;
        logic [ENTRIES-1:0]            refd;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic                          rsp_valid;
        rsp_kind_e                     rsp_kind;
        logic [PA_W-1:0]               rsp_paddr;
        logic                          rsp_dirty;
        logic                          rsp_ref;
    } state_t;

    state_t st_d, st_q;

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] lk_match;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic [ENTRIES-1:0] fl_match;
    logic               fl_any;
    logic [IDX_W-1:0]   fl_idx;
    logic [IDX_W-1:0]   rr_ptr;
    logic               rr_adv;

    assign lk_vpn = req_vaddr[VA_W-1:PAGE_BITS];

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W)) u_cam_lookup (
        .occ   (st_q.occ),
        .tags  (st_q.vpn),
        .key   (lk_vpn),
        .match (lk_match),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W)) u_cam_fill (
        .occ   (st_q.occ),
        .tags  (st_q.vpn),
        .key   (fill_vpn),
        .match (fl_match),
        .any   (fl_any),
        .idx   (fl_idx)
    );

    assign rr_adv = fill_valid && !flush && !fl_any;

    tlb_rr_ptr #(.N(ENTRIES)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush),
        .advance (rr_adv),
        .ptr     (rr_ptr)
    );

    always_comb begin
        logic [IDX_W-1:0] slot;
        st_d = st_q;

        // lookup against the table as registered
        st_d.rsp_valid = req_valid;
        st_d.rsp_kind  = RK_NONE;
        st_d.rsp_paddr = '0;
        st_d.rsp_dirty = 1'b0;
        st_d.rsp_ref   = 1'b0;
        if (req_valid) begin
            if (!lk_any) begin
                st_d.rsp_kind = RK_MISS;
            end else if (!st_q.res[lk_idx]) begin
                st_d.rsp_kind = RK_FAULT;
            end else begin
                st_d.rsp_kind  = RK_HIT;
                st_d.rsp_paddr = {st_q.pfn[lk_idx], req_vaddr[PAGE_BITS-1:0]};
                st_d.rsp_dirty = st_q.dirty[lk_idx];
                st_d.rsp_ref   = st_q.refd[lk_idx];
                st_d.refd[lk_idx] = 1'b1;
                if (req_write) st_d.dirty[lk_idx] = 1'b1;
            end
        end

        // maintenance: flush first, then refill (overrides status update)
        slot = fl_any ? fl_idx : rr_ptr;
        if (flush) begin
            st_d.occ = '0;
        end else if (fill_valid) begin
            st_d.occ[slot]   = 1'b1;
            st_d.res[slot]   = fill_resident;
            st_d.vpn[slot]   = fill_vpn;
            st_d.pfn[slot]   = fill_pfn;
            st_d.dirty[slot] = 1'b0;
            st_d.refd[slot]  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = (st_q.rsp_kind == RK_HIT);
    assign rsp_miss  = (st_q.rsp_kind == RK_MISS);
    assign rsp_fault = (st_q.rsp_kind == RK_FAULT);
    assign rsp_paddr = st_q.rsp_paddr;
    assign rsp_dirty = st_q.rsp_dirty;
    assign rsp_ref   = st_q.rsp_ref;

    // R1: a request is answered on the next cycle, and only then
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1: offset bits pass through untouched on a hit
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

    // R2: a miss carries no address
    a_r2_miss_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0));

    // R3: a fault carries no address
    a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));

    // R4: exactly one outcome per response, silence otherwise
    a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));
    a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref} == '0 && rsp_paddr == '0));

    // R8: refill policy keeps page numbers unique, so at most one slot matches
    a_r8_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    a_r8_unique_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_match));

    // R9: flush leaves no occupied slot
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.occ == '0));

endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;

    localparam logic [1:0] OP_LOOK = 2'd0;
    localparam logic [1:0] OP_FILL = 2'd1;
    localparam logic [1:0] K_HIT   = 2'd1;
    localparam logic [1:0] K_MISS  = 2'd2;
    localparam logic [1:0] K_FAULT = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic        wr;
        logic [31:0] addr;
        logic [19:0] pfn;
        logic        res;
        logic [1:0]  kind;
        logic [31:0] pa;
        logic        d;
        logic        r;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{OP_FILL, 1'b0, 32'h0001_0000, 20'h00AAA, 1'b1, 2'd0,    32'h0,         1'b0, 1'b0},
        '{OP_LOOK, 1'b0, 32'h0001_0123, 20'h0,     1'b0, K_HIT,   32'h00AA_A123, 1'b0, 1'b0},
        '{OP_LOOK, 1'b1, 32'h0001_0FFF, 20'h0,     1'b0, K_HIT,   32'h00AA_AFFF, 1'b0, 1'b1},
        '{OP_LOOK, 1'b0, 32'h0001_0000, 20'h0,     1'b0, K_HIT,   32'h00AA_A000, 1'b1, 1'b1},
        '{OP_LOOK, 1'b0, 32'h0002_0456, 20'h0,     1'b0, K_MISS,  32'h0,         1'b0, 1'b0},
        '{OP_FILL, 1'b0, 32'h0002_0000, 20'h12345, 1'b0, 2'd0,    32'h0,         1'b0, 1'b0},
        '{OP_LOOK, 1'b1, 32'h0002_0456, 20'h0,     1'b0, K_FAULT, 32'h0,         1'b0, 1'b0},
        '{OP_FILL, 1'b0, 32'h0002_0000, 20'h54321, 1'b1, 2'd0,    32'h0,         1'b0, 1'b0},
        '{OP_LOOK, 1'b1, 32'h0002_0ABC, 20'h0,     1'b0, K_HIT,   32'h5432_1ABC, 1'b0, 1'b0},
        '{OP_FILL, 1'b0, 32'h0001_0000, 20'h0BBBB, 1'b1, 2'd0,    32'h0,         1'b0, 1'b0},
        '{OP_LOOK, 1'b0, 32'h0001_0001, 20'h0,     1'b0, K_HIT,   32'h0BBB_B001, 1'b0, 1'b0}
    };
    localparam string VREQ [NV] = '{"R7", "R1", "R6", "R6", "R2", "R7",
                                    "R3", "R8", "R3", "R8", "R6"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        flush = 1'b0, fill_valid = 1'b0, fill_resident = 1'b0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref;
    logic [31:0] rsp_paddr;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tlb_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .flush(flush), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_resident(fill_resident),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one cycle of stimulus, starting and ending on a falling edge
    task automatic step(input bit look, input bit wr, input logic [31:0] va,
                        input bit fill, input logic [19:0] vpn, input logic [19:0] pfn,
                        input bit res, input bit fl);
        req_valid = look; req_write = wr; req_vaddr = va;
        fill_valid = fill; fill_vpn = vpn; fill_pfn = pfn; fill_resident = res;
        flush = fl;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; fill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic [1:0] kind,
                              input logic [31:0] pa, input bit d, input bit r);
        chk(req, "valid", 64'(rsp_valid), 64'd1);
        chk(req, "kind", 64'({rsp_hit, rsp_miss, rsp_fault}),
            64'(kind == K_HIT ? 3'b100 : kind == K_MISS ? 3'b010 : 3'b001));
        chk(req, "paddr", 64'(rsp_paddr), 64'(pa));
        chk(req, "dirty", 64'(rsp_dirty), 64'(d));
        chk(req, "ref", 64'(rsp_ref), 64'(r));
    endtask

    task automatic look(input string req, input bit wr, input logic [31:0] va,
                        input logic [1:0] kind, input logic [31:0] pa,
                        input bit d, input bit r);
        step(1'b1, wr, va, 1'b0, '0, '0, 1'b0, 1'b0);
        expect_rsp(req, kind, pa, d, r);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input bit res);
        step(1'b0, 1'b0, '0, 1'b1, vpn, pfn, res, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        chk("R10", "outputs in reset",
            64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref}), 64'd0);
        chk("R10", "paddr in reset", 64'(rsp_paddr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: empty buffer, even page number 0 misses
        look("R10", 1'b0, 32'h0000_0123, K_MISS, 32'h0, 1'b0, 1'b0);
        // R4: idle cycle gives no response
        @(negedge clk);
        chk("R4", "idle outputs",
            64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op == OP_FILL) begin
                fill(VEC[i].addr[31:12], VEC[i].pfn, VEC[i].res);
                chk(VREQ[i], "no response for refill", 64'(rsp_valid), 64'd0);
            end else begin
                look(VREQ[i], VEC[i].wr, VEC[i].addr, VEC[i].kind,
                     VEC[i].pa, VEC[i].d, VEC[i].r);
            end
        end

        // R7: slots 0,1 used; six new pages fill slots 2..7, ninth new page reuses slot 0
        for (int k = 0; k < 6; k++) fill(20'h00100 + 20'(k), 20'h0C000 + 20'(k), 1'b1);
        fill(20'h00200, 20'h0D200, 1'b1);
        look("R7", 1'b0, 32'h0001_0010, K_MISS, 32'h0, 1'b0, 1'b0);
        look("R8", 1'b0, 32'h0002_0020, K_HIT, 32'h5432_1020, 1'b1, 1'b1);
        look("R7", 1'b0, 32'h0010_5777, K_HIT, 32'h0C00_5777, 1'b0, 1'b0);
        look("R7", 1'b0, 32'h0020_0008, K_HIT, 32'h0D20_0008, 1'b0, 1'b0);
        fill(20'h00201, 20'h0D201, 1'b1);
        look("R7", 1'b0, 32'h0002_0020, K_MISS, 32'h0, 1'b0, 1'b0);

        // R11: lookup with a same-cycle refill of its page still misses
        step(1'b1, 1'b0, 32'h0030_0044, 1'b1, 20'h00300, 20'h0E300, 1'b1, 1'b0);
        expect_rsp("R11", K_MISS, 32'h0, 1'b0, 1'b0);
        look("R11", 1'b0, 32'h0030_0044, K_HIT, 32'h0E30_0044, 1'b0, 1'b0);

        // R11 and R9: lookup in the flush cycle still hits, then the buffer is empty
        step(1'b1, 1'b0, 32'h0020_0010, 1'b1, 20'h00400, 20'h0F400, 1'b1, 1'b1);
        expect_rsp("R11", K_HIT, 32'h0D20_0010, 1'b0, 1'b1);
        look("R9", 1'b0, 32'h0020_0010, K_MISS, 32'h0, 1'b0, 1'b0);
        look("R9", 1'b0, 32'h0030_0000, K_MISS, 32'h0, 1'b0, 1'b0);
        look("R9", 1'b0, 32'h0040_0000, K_MISS, 32'h0, 1'b0, 1'b0);

        // R9: pointer back at slot 0: eight new pages fill, ninth evicts the first
        for (int k = 0; k < 8; k++) fill(20'h00500 + 20'(k), 20'h01500 + 20'(k), 1'b1);
        look("R9", 1'b0, 32'h0050_0abc, K_HIT, 32'h0150_0ABC, 1'b0, 1'b0);
        fill(20'h00600, 20'h01600, 1'b1);
        look("R9", 1'b0, 32'h0050_0abc, K_MISS, 32'h0, 1'b0, 1'b0);
        look("R9", 1'b0, 32'h0050_1abc, K_HIT, 32'h0150_1ABC, 1'b0, 1'b0);

        // R5: read hit sets referenced without dirty
        look("R5", 1'b0, 32'h0050_2000, K_HIT, 32'h0150_2000, 1'b0, 1'b0);
        look("R5", 1'b0, 32'h0050_2001, K_HIT, 32'h0150_2001, 1'b0, 1'b1);

        finish_run();
    end

endmodule